// File: doc/BRIEF.md
# Eight-Bit Timer with Shared Power-of-Two Prescaler

This block is an eight-bit up-counter that raises a sticky wrap flag when it rolls from 0xFF to 0x00. It counts one of two sources. The first is an internal tick at one quarter of the system clock. The second is an external pin, and a control bit picks which pin edge counts.

A single power-of-two prescaler sits between the chosen source and its consumer. A routing bit gives the prescaler either to this counter or to a watchdog. When the prescaler is given to the watchdog, the counter sees every source event (1:1), and the watchdog tick output pulses once per prescaled period. When the prescaler is given to the counter, a 3-bit rate field divides the source by 2^(rate+1), which covers 1:2 to 1:256. In that case the watchdog tick pulses once per undivided source event.

The prescaler is clocked directly by the selected source. Only its output is brought into the system clock domain. An external pin can therefore toggle faster than the system clock, provided the prescaled rate stays slow enough to be sampled. Watchdog reset behaviour beyond the tick is handled elsewhere.

Top module: `tmr_shared_psc`

## Requirements
- R1: After synchronous reset, `count` reads 0, `wrap_flag` reads 0 and `wdog_tick` reads 0. Outside a write, `count` only ever holds its value or advances by exactly one.
- R2: With `use_ext`=0 and `psc_to_wdog`=1, `count` advances once every 4 system clocks. With `psc_to_wdog`=0 and `rate`=0 it advances every 8 clocks, and with `rate`=1 every 16 clocks.
- R3: With `use_ext`=1, `fall_edge`=0 makes a low-to-high transition of `ext_in` count. `fall_edge`=1 makes a high-to-low transition count, and the opposite transition then has no effect on `count`.
- R4: With `psc_to_wdog`=1, every counted source event advances `count` by one, whatever `rate` holds.
- R5: With `psc_to_wdog`=0, `count` advances once per 2^(`rate`+1) counted source events. After a prescaler clear, 2^(`rate`+1)-1 events leave `count` unchanged, and the next event advances it.
- R6: A cycle with `wr_en`=1 makes `count` equal `wr_data` at the next clock edge. It clears the prescaler when `psc_to_wdog`=0. For a short hold window after the write, the counter does not advance.
- R7: `wrap_flag` sets when `count` advances from 0xFF to 0x00. It stays set through further counting and is cleared only by `wrap_clr`; if a set and a clear arrive in the same cycle, the set wins.
- R8: With `psc_to_wdog`=1, `wdog_tick` gives one single-cycle pulse per 2^(`rate`+1) source events. With `psc_to_wdog`=0, it gives one pulse per source event.
- R9: The external pin is divided before it is synchronized. A pin toggling at twice the system clock rate, with `rate`=7 assigned to the counter, advances `count` once per 256 pin cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| use_ext | input | 1 | 1 selects the external pin, 0 selects the internal quarter-rate tick |
| fall_edge | input | 1 | 1 counts falling pin edges, 0 counts rising pin edges |
| psc_to_wdog | input | 1 | 1 routes the prescaler to the watchdog, 0 routes it to the counter |
| rate | input | 3 | Prescaler rate; the divide ratio is 2^(rate+1) |
| wr_en | input | 1 | Load `wr_data` into the counter |
| wr_data | input | 8 | Value to load |
| wrap_clr | input | 1 | Clear the wrap flag |
| ext_in | input | 1 | External clock pin |
| count | output | 8 | Current counter value |
| wrap_flag | output | 1 | Sticky flag set on 0xFF to 0x00 |
| wdog_tick | output | 1 | Single-cycle pulse toward the watchdog |

## Verification
The bench applies exactly one event fewer than the divide ratio at rates 0, 2 and 7, then the final event. A prescaler tapped one bit off would advance early or late. It repeats this after a mid-period write, which catches a design that keeps stale prescaler residue. The bench holds the external pin high and looks for no movement in falling-edge mode, so an inverted polarity select would advance on the wrong transition. It drives the pin faster than the system clock, where a design that synchronizes before dividing would lose edges and fall short of the expected count. It also checks that the wrap flag survives further counting and yields only to its clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned RATE_W_DEF = 3;
  localparam int unsigned DIV_W_DEF  = 2;
  localparam int unsigned SYNC_DEF   = 2;

  typedef struct packed {
    logic       use_ext;
    logic       fall_edge;
    logic       psc_to_wdog;
    logic [RATE_W_DEF-1:0] rate;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_clk_src.sv
module tmr_clk_src #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic use_ext,
  input  logic fall_edge,
  input  logic ext_in,
  output logic src_clk
);
  logic [DIV_W-1:0] phase;
  logic             int_clk;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  // registered MSB of the divider: a 50% duty clock at clk / 2^DIV_W
  assign int_clk = phase[DIV_W-1];
  // XOR with the edge select turns a falling pin edge into a rising src edge
  assign src_clk = use_ext ? (ext_in ^ fall_edge) : int_clk;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned RATE_W = 3
) (
  input  logic              src_clk,
  input  logic              clr,
  input  logic              psc_to_wdog,
  input  logic [RATE_W-1:0] rate,
  output logic              tmr_tap,
  output logic              wdog_tap
);
  localparam int unsigned PSC_W = 2 ** RATE_W;

  logic [PSC_W-1:0] psc;
  logic             div_tap;

  // Runs in the source domain; cleared asynchronously from the system domain.
  always_ff @(posedge src_clk or posedge clr) begin
    if (clr) psc <= '0;
    else     psc <= psc + 1'b1;
  end

  // Bit r falls once every 2^(r+1) source edges; inverted it rises then.
  assign div_tap  = ~psc[rate];
  assign tmr_tap  = psc_to_wdog ? src_clk : div_tap;
  assign wdog_tap = psc_to_wdog ? div_tap : src_clk;
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= 1'b0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      prev  <= chain[STAGES-1];
      pulse <= chain[STAGES-1] & ~prev;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned HOLD  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap_clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap_flag
);
  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] hold_cnt;
  logic          step;

  assign step = inc && (hold_cnt == '0) && !wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      hold_cnt <= HOLD_V;
    end else if (wr_en) begin
      count    <= wr_data;
      hold_cnt <= HOLD_V;
    end else begin
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (step)           count    <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      wrap_flag <= 1'b0;
    else if (step && (&count))    wrap_flag <= 1'b1;
    else if (wrap_clr)            wrap_flag <= 1'b0;
  end
endmodule

// File: rtl/tmr_shared_psc.sv
module tmr_shared_psc
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned RATE_W = RATE_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned SYNC   = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_ext,
  input  logic              fall_edge,
  input  logic              psc_to_wdog,
  input  logic [RATE_W-1:0] rate,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wrap_clr,
  input  logic              ext_in,
  output logic [CNT_W-1:0]  count,
  output logic              wrap_flag,
  output logic              wdog_tick
);
  // clear reaches the taps, crosses SYNC flops, then the pulse flop
  localparam int unsigned HOLD = SYNC + 4;

  logic src_clk, psc_clr, tmr_tap, wdog_tap, tmr_inc;

  always_ff @(posedge clk) begin
    if (rst) psc_clr <= 1'b1;
    else     psc_clr <= wr_en & ~psc_to_wdog;
  end

  tmr_clk_src #(.DIV_W(DIV_W)) u_src (
    .clk(clk), .rst(rst), .use_ext(use_ext), .fall_edge(fall_edge),
    .ext_in(ext_in), .src_clk(src_clk));

  tmr_prescaler #(.RATE_W(RATE_W)) u_psc (
    .src_clk(src_clk), .clr(psc_clr), .psc_to_wdog(psc_to_wdog),
    .rate(rate), .tmr_tap(tmr_tap), .wdog_tap(wdog_tap));

  tmr_edge_sync #(.STAGES(SYNC)) u_sync_tmr (
    .clk(clk), .rst(rst), .async_in(tmr_tap), .pulse(tmr_inc));

  tmr_edge_sync #(.STAGES(SYNC)) u_sync_wdog (
    .clk(clk), .rst(rst), .async_in(wdog_tap), .pulse(wdog_tick));

  tmr_count_core #(.CNT_W(CNT_W), .HOLD(HOLD)) u_core (
    .clk(clk), .rst(rst), .inc(tmr_inc), .wr_en(wr_en), .wr_data(wr_data),
    .wrap_clr(wrap_clr), .count(count), .wrap_flag(wrap_flag));
endmodule

// File: rtl/tmr_shared_psc_chk.sv
module tmr_shared_psc_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             wrap_clr,
  input logic [CNT_W-1:0] count,
  input logic             wrap_flag
);
  // R1: without a write the count holds or steps by one
  a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  // R6: a write lands on the next edge
  a_r6_write_loads: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count == $past(wr_data)));

  // R6: no advance in the cycle after a load
  a_r6_hold_after_write: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en, 2) && !$past(wr_en)) |-> (count == $past(count)));

  // R7: wrap sets the flag
  a_r7_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && (&$past(count)) && count == '0) |-> wrap_flag);

  // R7: flag is sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !wrap_clr) |=> wrap_flag);
endmodule

bind tmr_shared_psc tmr_shared_psc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .wrap_clr(wrap_clr), .count(count), .wrap_flag(wrap_flag));

// File: tb/tb_tmr_shared_psc.sv
`timescale 1ns/1ps
module tb_tmr_shared_psc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       use_ext = 1'b0, fall_edge = 1'b0, psc_to_wdog = 1'b1;
  logic [2:0] rate = 3'd0;
  logic       wr_en = 1'b0, wrap_clr = 1'b0, ext_in = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count;
  logic       wrap_flag, wdog_tick;

  int checks = 0, fails = 0, wd_seen = 0;

  always #10 clk = ~clk;

  tmr_shared_psc dut (
    .clk(clk), .rst(rst), .use_ext(use_ext), .fall_edge(fall_edge),
    .psc_to_wdog(psc_to_wdog), .rate(rate), .wr_en(wr_en), .wr_data(wr_data),
    .wrap_clr(wrap_clr), .ext_in(ext_in), .count(count),
    .wrap_flag(wrap_flag), .wdog_tick(wdog_tick));

  always @(negedge clk) if (!rst && wdog_tick) wd_seen++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic load(logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic setup(logic ext, logic fall, logic wd, logic [2:0] r);
    @(negedge clk);
    use_ext = ext; fall_edge = fall; psc_to_wdog = wd; rate = r;
    repeat (10) @(negedge clk);
    load(8'd0);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; repeat (6) @(negedge clk);
      ext_in = 1'b0; repeat (6) @(negedge clk);
    end
  endtask

  task automatic gap(output int cyc);
    logic [7:0] c0;
    c0 = count;
    while (count == c0) @(negedge clk);
    c0 = count; cyc = 0;
    while (count == c0) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    check("R1 count after reset", count, 0);
    check("R1 wrap after reset", wrap_flag, 0);
    check("R1 wdog after reset", wdog_tick, 0);
  endtask

  task automatic t_internal();
    int c;
    setup(1'b0, 1'b0, 1'b1, 3'd0); gap(c); check("R2 internal 1:1 period", c, 4);
    setup(1'b0, 1'b0, 1'b0, 3'd0); gap(c); check("R2 internal 1:2 period", c, 8);
    setup(1'b0, 1'b0, 1'b0, 3'd1); gap(c); check("R2 internal 1:4 period", c, 16);
  endtask

  task automatic t_edges();
    setup(1'b1, 1'b0, 1'b1, 3'd0);
    ext_in = 1'b1; repeat (6) @(negedge clk);
    check("R3 rising mode advances on rise", count, 1);
    ext_in = 1'b0; repeat (6) @(negedge clk);
    check("R3 rising mode ignores fall", count, 1);
    setup(1'b1, 1'b1, 1'b1, 3'd0);
    ext_in = 1'b1; repeat (6) @(negedge clk);
    check("R3 falling mode ignores rise", count, 0);
    ext_in = 1'b0; repeat (6) @(negedge clk);
    check("R3 falling mode advances on fall", count, 1);
  endtask

  task automatic t_rates();
    int r_list[3] = '{0, 2, 7};
    foreach (r_list[k]) begin
      int n = 1 << (r_list[k] + 1);
      setup(1'b1, 1'b0, 1'b0, 3'(r_list[k]));
      pulses(n - 1);
      check($sformatf("R5 rate %0d one short", r_list[k]), count, 0);
      pulses(1);
      check($sformatf("R5 rate %0d full period", r_list[k]), count, 1);
    end
  endtask

  task automatic t_write();
    setup(1'b1, 1'b0, 1'b0, 3'd2);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk); wr_en = 1'b0;
    check("R6 write readback", count, 8'h5A);
    repeat (10) @(negedge clk);
    pulses(5);
    load(8'h10);
    pulses(7);
    check("R6 prescaler cleared by write", count, 8'h10);
    pulses(1);
    check("R6 first period after write", count, 8'h11);
  endtask

  task automatic t_wrap();
    setup(1'b1, 1'b0, 1'b1, 3'd0);
    load(8'hFE);
    pulses(1);
    check("R7 no wrap at FF", wrap_flag, 0);
    pulses(1);
    check("R7 count wraps to zero", count, 0);
    check("R7 wrap flag set", wrap_flag, 1);
    pulses(3);
    check("R7 wrap flag sticky", wrap_flag, 1);
    @(negedge clk); wrap_clr = 1'b1;
    @(negedge clk); wrap_clr = 1'b0;
    check("R7 wrap flag cleared", wrap_flag, 0);
  endtask

  task automatic t_wdog();
    setup(1'b1, 1'b0, 1'b1, 3'd1);
    wd_seen = 0;
    pulses(8);
    check("R4 timer 1:1 when prescaler on watchdog", count, 8);
    check("R8 watchdog ticks at 1:4", wd_seen, 2);
    setup(1'b1, 1'b0, 1'b0, 3'd3);
    wd_seen = 0;
    pulses(3);
    check("R8 watchdog undivided when prescaler on timer", wd_seen, 3);
  endtask

  task automatic t_fast();
    setup(1'b1, 1'b0, 1'b0, 3'd7);
    for (int i = 0; i < 1024; i++) #5 ext_in = ~ext_in;
    repeat (10) @(negedge clk);
    check("R9 fast pin divided before sync", count, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_internal();
    t_edges();
    t_rates();
    t_write();
    t_wrap();
    t_wdog();
    t_fast();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule